// File: doc/BRIEF.md
# Interlaced Field Sequencer

This block steps a raster display through one interlaced field at a time. It counts scan-line strobes and moves through six phases in a fixed order: vertical sync asserted, vertical sync released, top border, a one-line picture lead-in, picture, and bottom border. Then it starts the next field. When it enters a phase it writes a 16-bit command word for the display controller and pulses a write strobe for one cycle. Each field has the opposite parity to the one before it. That parity sets how long vertical sync lasts, which scan lines the picture covers, and one bit of the sync command word.

When the top border begins, the block loads the border pattern. This is the configured pattern if the display has been initialised, and a fixed dotted default if it has not. At the same moment it takes the picture length for the field, sets the configured wake-up bits in a pending register and raises a one-cycle interrupt request. On odd fields it also advances a frame counter. All other inputs are configuration values that the block samples at the moment it needs them.

Top module: `field_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released: `phase_out` is 0, `field_odd` is 0, `ctl_word` is 0x0023, `ctl_wr` and `irq_req` are 0, and `wake_pending`, `border_out` and `frame_count` are zero.
- R2: The phase codes are 0 = sync asserted, 1 = sync released, 2 = top border, 3 = picture lead-in, 4 = picture, 5 = bottom border. They always run in the order 0,1,2,3,4,5,0. The phase changes only on a clock edge where `line_tick` is high, and the new value is visible in the next cycle.
- R3: Phase 0 lasts 17 line strobes on an even field and 18 on an odd field. Phase 1 lasts 2, phase 2 lasts 13, phase 3 lasts 1 and phase 5 lasts 12.
- R4: `field_odd` inverts on the same edge that enters phase 0 and at no other time.
- R5: On entry to phase 0 the command word is 0x023 in bits 10..0, the new parity in bit 11, and zero in bits 15..12. On entry to phase 1 the command word is 0x0003.
- R6: `ctl_wr` is high for exactly one cycle, on entry to phases 0, 1, 2, 4 and 5. It stays low on entry to phase 3 and at all other times. The word written is `cfg_sync_cmd` for phases 2 and 5 and `cfg_field_cmd` for phase 4.
- R7: The picture line index starts at the field parity and steps by 2 on each strobe. The picture ends when the index reaches the picture length with its bit 0 replaced by the parity. Phases 3 and 4 together therefore last `cfg_pic_len`/2 lines, and `cfg_pic_len` must be at least 4.
- R8: `cfg_pic_len` is sampled on entry to phase 2. A change after that point has no effect on the current field.
- R9: On entry to phase 2, `border_out` takes `cfg_border` if `init_done` is high, and 0x8822 if it is low.
- R10: On entry to phase 2, `cfg_wake_mask` is ORed into `wake_pending` and `irq_req` pulses for one cycle. Bits in `wake_pending` are never cleared except by reset.
- R11: `frame_count` increases by 1 on entry to phase 2 of an odd field and is unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_tick | input | 1 | One-cycle strobe per scan line |
| init_done | input | 1 | Display has been initialised |
| cfg_pic_len | input | 16 | Picture length, in scan lines of both fields |
| cfg_border | input | 16 | Configured border pattern |
| cfg_sync_cmd | input | 16 | Command word for the border phases |
| cfg_field_cmd | input | 16 | Command word that starts the visible picture |
| cfg_wake_mask | input | 16 | Wake-up bits set once per field |
| ctl_word | output | 16 | Current display command word |
| ctl_wr | output | 1 | One-cycle write strobe for `ctl_word` |
| irq_req | output | 1 | One-cycle wake-up interrupt request |
| wake_pending | output | 16 | Accumulated wake-up bits |
| border_out | output | 16 | Border pattern in use |
| field_odd | output | 1 | Parity of the current field |
| frame_count | output | CLK_W | Frame counter |
| phase_out | output | 3 | Current phase code |

## Verification
Two pairs of events share a clock cycle. On entry to the top border, the command write, the border load, the pending-register update, the interrupt pulse and (on odd fields) the frame-count step all happen in one cycle. On entry to vertical sync, the parity flip and the command write happen together, and the word written must already carry the new parity. The bench steps through fields of both parities, alternating the initialised flag and the wake masks. In the single cycle after each transition strobe it checks every affected output. It also changes the picture length during the lead-in line to show that the field keeps the length it sampled earlier.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [2:0] {
    PH_VSYNC = 3'd0,
    PH_VEND  = 3'd1,
    PH_TOP   = 3'd2,
    PH_LEAD  = 3'd3,
    PH_PIC   = 3'd4,
    PH_BOT   = 3'd5
  } phase_t;

  localparam logic [15:0] SYNC_ON_CODE   = 16'h0023;
  localparam logic [15:0] SYNC_OFF_CODE  = 16'h0003;
  localparam logic [15:0] DEFAULT_BORDER = 16'h8822;
  localparam int          PARITY_POS     = 11;

  // command word written when vertical sync starts; carries parity
  function automatic logic [15:0] sync_on_word(input logic odd);
    sync_on_word = SYNC_ON_CODE | (16'(odd) << PARITY_POS);
  endfunction

  // picture end index: configured length with its low bit set to parity
  function automatic logic [15:0] pic_limit(input logic [15:0] len,
                                            input logic odd);
    pic_limit = (len & 16'hFFFE) | 16'(odd);
  endfunction

  function automatic phase_t phase_after(input phase_t p);
    case (p)
      PH_VSYNC: phase_after = PH_VEND;
      PH_VEND:  phase_after = PH_TOP;
      PH_TOP:   phase_after = PH_LEAD;
      PH_LEAD:  phase_after = PH_PIC;
      PH_PIC:   phase_after = PH_BOT;
      default:  phase_after = PH_VSYNC;
    endcase
  endfunction

endpackage

// File: rtl/fseq_phase.sv
module fseq_phase
  import fseq_pkg::*;
#(
  parameter int VS_LINES   = 17,
  parameter int VEND_LINES = 2,
  parameter int TOP_LINES  = 13,
  parameter int BOT_LINES  = 12
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   line_tick,
  input  logic   pic_done,
  output phase_t phase,
  output logic   field_odd,
  output logic   adv,
  output phase_t nxt,
  output logic   nxt_odd
);

  localparam int MAX_A = (VS_LINES + 1 > TOP_LINES) ? VS_LINES + 1 : TOP_LINES;
  localparam int MAX_B = (BOT_LINES > VEND_LINES) ? BOT_LINES : VEND_LINES;
  localparam int MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_L + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             last;

  always_comb begin
    case (phase)
      PH_VSYNC: lim = CNT_W'(VS_LINES) + CNT_W'(field_odd);
      PH_VEND:  lim = CNT_W'(VEND_LINES);
      PH_TOP:   lim = CNT_W'(TOP_LINES);
      PH_BOT:   lim = CNT_W'(BOT_LINES);
      default:  lim = CNT_W'(1);
    endcase
    last    = (phase == PH_PIC) ? pic_done : (cnt == lim - CNT_W'(1));
    adv     = line_tick & last;
    nxt     = phase_after(phase);
    nxt_odd = (nxt == PH_VSYNC) ? ~field_odd : field_odd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_VSYNC;
      cnt       <= '0;
      field_odd <= 1'b0;
    end else if (line_tick) begin
      if (last) begin
        phase     <= nxt;
        cnt       <= '0;
        field_odd <= nxt_odd;
      end else if (phase != PH_PIC) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/fseq_scan.sv
module fseq_scan
  import fseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        line_tick,
  input  phase_t      phase,
  input  logic        field_odd,
  input  logic        adv,
  input  phase_t      nxt,
  input  logic [15:0] cfg_pic_len,
  output logic        pic_done
);

  logic [15:0] line_idx;
  logic [15:0] line_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_idx <= '0;
      line_end <= '0;
    end else begin
      if (adv && nxt == PH_TOP)
        line_end <= pic_limit(cfg_pic_len, field_odd);
      if (adv && nxt == PH_LEAD)
        line_idx <= 16'(field_odd);
      else if (line_tick && (phase == PH_LEAD || phase == PH_PIC))
        line_idx <= line_idx + 16'd2;
    end
  end

  assign pic_done = (phase == PH_PIC) && (line_idx + 16'd2 == line_end);

endmodule

// File: rtl/fseq_events.sv
module fseq_events
  import fseq_pkg::*;
#(
  parameter int CLK_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  phase_t           nxt,
  input  logic             nxt_odd,
  input  logic             field_odd,
  input  logic             init_done,
  input  logic [15:0]      cfg_border,
  input  logic [15:0]      cfg_sync_cmd,
  input  logic [15:0]      cfg_field_cmd,
  input  logic [15:0]      cfg_wake_mask,
  output logic [15:0]      ctl_word,
  output logic             ctl_wr,
  output logic             irq_req,
  output logic [15:0]      wake_pending,
  output logic [15:0]      border_out,
  output logic [CLK_W-1:0] frame_count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_word     <= sync_on_word(1'b0);
      ctl_wr       <= 1'b0;
      irq_req      <= 1'b0;
      wake_pending <= '0;
      border_out   <= '0;
      frame_count  <= '0;
    end else begin
      ctl_wr  <= 1'b0;
      irq_req <= 1'b0;
      if (adv) begin
        case (nxt)
          PH_VSYNC: begin
            ctl_word <= sync_on_word(nxt_odd);
            ctl_wr   <= 1'b1;
          end
          PH_VEND: begin
            ctl_word <= SYNC_OFF_CODE;
            ctl_wr   <= 1'b1;
          end
          PH_TOP: begin
            ctl_word     <= cfg_sync_cmd;
            ctl_wr       <= 1'b1;
            border_out   <= init_done ? cfg_border : DEFAULT_BORDER;
            wake_pending <= wake_pending | cfg_wake_mask;
            irq_req      <= 1'b1;
            if (field_odd) frame_count <= frame_count + CLK_W'(1);
          end
          PH_PIC: begin
            ctl_word <= cfg_field_cmd;
            ctl_wr   <= 1'b1;
          end
          PH_BOT: begin
            ctl_word <= cfg_sync_cmd;
            ctl_wr   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/field_seq.sv
module field_seq
  import fseq_pkg::*;
#(
  parameter int VS_LINES   = 17,
  parameter int VEND_LINES = 2,
  parameter int TOP_LINES  = 13,
  parameter int BOT_LINES  = 12,
  parameter int CLK_W      = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_tick,
  input  logic             init_done,
  input  logic [15:0]      cfg_pic_len,
  input  logic [15:0]      cfg_border,
  input  logic [15:0]      cfg_sync_cmd,
  input  logic [15:0]      cfg_field_cmd,
  input  logic [15:0]      cfg_wake_mask,
  output logic [15:0]      ctl_word,
  output logic             ctl_wr,
  output logic             irq_req,
  output logic [15:0]      wake_pending,
  output logic [15:0]      border_out,
  output logic             field_odd,
  output logic [CLK_W-1:0] frame_count,
  output logic [2:0]       phase_out
);

  phase_t phase;
  phase_t phase_nxt;
  logic   phase_adv;
  logic   odd_nxt;
  logic   pic_done;

  fseq_phase #(
    .VS_LINES  (VS_LINES),
    .VEND_LINES(VEND_LINES),
    .TOP_LINES (TOP_LINES),
    .BOT_LINES (BOT_LINES)
  ) u_phase (
    .clk      (clk),
    .rst      (rst),
    .line_tick(line_tick),
    .pic_done (pic_done),
    .phase    (phase),
    .field_odd(field_odd),
    .adv      (phase_adv),
    .nxt      (phase_nxt),
    .nxt_odd  (odd_nxt)
  );

  fseq_scan u_scan (
    .clk        (clk),
    .rst        (rst),
    .line_tick  (line_tick),
    .phase      (phase),
    .field_odd  (field_odd),
    .adv        (phase_adv),
    .nxt        (phase_nxt),
    .cfg_pic_len(cfg_pic_len),
    .pic_done   (pic_done)
  );

  fseq_events #(.CLK_W(CLK_W)) u_events (
    .clk          (clk),
    .rst          (rst),
    .adv          (phase_adv),
    .nxt          (phase_nxt),
    .nxt_odd      (odd_nxt),
    .field_odd    (field_odd),
    .init_done    (init_done),
    .cfg_border   (cfg_border),
    .cfg_sync_cmd (cfg_sync_cmd),
    .cfg_field_cmd(cfg_field_cmd),
    .cfg_wake_mask(cfg_wake_mask),
    .ctl_word     (ctl_word),
    .ctl_wr       (ctl_wr),
    .irq_req      (irq_req),
    .wake_pending (wake_pending),
    .border_out   (border_out),
    .frame_count  (frame_count)
  );

  assign phase_out = phase;

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
  parameter int CLK_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             init_done,
  input logic             phase_adv,
  input logic [2:0]       phase_out,
  input logic             field_odd,
  input logic [15:0]      ctl_word,
  input logic             ctl_wr,
  input logic             irq_req,
  input logic [15:0]      wake_pending,
  input logic [15:0]      border_out,
  input logic [CLK_W-1:0] frame_count
);

  // R2
  phase_legal_chk: assert property (@(posedge clk) disable iff (rst)
    phase_out <= 3'd5);

  // R2
  adv_moves_chk: assert property (@(posedge clk) disable iff (rst)
    phase_adv |=> (phase_out != $past(phase_out)));

  // R6
  wr_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |-> (phase_out != $past(phase_out)));

  // R6
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> !ctl_wr);

  // R4
  parity_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && phase_out == 3'd0) |-> (field_odd != $past(field_odd)));

  // R4
  parity_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr && phase_out == 3'd0) |-> $stable(field_odd));

  // R5
  sync_word_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && phase_out == 3'd0) |->
      (ctl_word[15:12] == 4'd0 && ctl_word[11] == field_odd && ctl_word[10:0] == 11'h023));

  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> !irq_req);

  // R10
  irq_at_top_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (ctl_wr && phase_out == 3'd2));

  // R10
  pending_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_pending & $past(wake_pending)) == $past(wake_pending));

  // R9
  border_dflt_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !$past(init_done)) |-> (border_out == 16'h8822));

  // R11
  frame_step_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_count != $past(frame_count)) |->
      (irq_req && field_odd && frame_count == $past(frame_count) + CLK_W'(1)));

endmodule

bind field_seq fseq_chk #(.CLK_W(CLK_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .init_done   (init_done),
  .phase_adv   (phase_adv),
  .phase_out   (phase_out),
  .field_odd   (field_odd),
  .ctl_word    (ctl_word),
  .ctl_wr      (ctl_wr),
  .irq_req     (irq_req),
  .wake_pending(wake_pending),
  .border_out  (border_out),
  .frame_count (frame_count)
);

// File: tb/field_seq_bench.sv
module field_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_tick = 1'b0;
  logic        init_done = 1'b0;
  logic [15:0] cfg_pic_len = 16'd8;
  logic [15:0] cfg_border = 16'h0;
  logic [15:0] cfg_sync_cmd = 16'h0;
  logic [15:0] cfg_field_cmd = 16'h0;
  logic [15:0] cfg_wake_mask = 16'h0;
  logic [15:0] ctl_word;
  logic        ctl_wr;
  logic        irq_req;
  logic [15:0] wake_pending;
  logic [15:0] border_out;
  logic        field_odd;
  logic [31:0] frame_count;
  logic [2:0]  phase_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic        exp_odd;
  logic [15:0] exp_pend;
  logic [31:0] exp_frame;

  always #5 clk = ~clk;

  field_seq u_field_seq (
    .clk          (clk),
    .rst          (rst),
    .line_tick    (line_tick),
    .init_done    (init_done),
    .cfg_pic_len  (cfg_pic_len),
    .cfg_border   (cfg_border),
    .cfg_sync_cmd (cfg_sync_cmd),
    .cfg_field_cmd(cfg_field_cmd),
    .cfg_wake_mask(cfg_wake_mask),
    .ctl_word     (ctl_word),
    .ctl_wr       (ctl_wr),
    .irq_req      (irq_req),
    .wake_pending (wake_pending),
    .border_out   (border_out),
    .field_odd    (field_odd),
    .frame_count  (frame_count),
    .phase_out    (phase_out)
  );

  // {init_done, border, picture length, wake mask}
  localparam logic [48:0] VEC [5] = '{
    {1'b0, 16'h1234, 16'd8,  16'h0001},
    {1'b1, 16'h5A5A, 16'd8,  16'h0010},
    {1'b1, 16'h0F0F, 16'd10, 16'h0100},
    {1'b0, 16'hFFFF, 16'd6,  16'h0002},
    {1'b1, 16'hC3C3, 16'd4,  16'h8000}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) line_tick = 1'b1;
    @(negedge clk) line_tick = 1'b0;
  endtask

  // n strobes in phase cur, the last one must move to nx and write exp_word
  task automatic step(input int n, input logic [2:0] cur, input logic [2:0] nx,
                      input logic exp_wr, input logic [15:0] exp_word,
                      input string tag_len, input string tag_word);
    bit quiet = 1'b1;
    for (int k = 0; k < n; k++) begin
      do_tick();
      if (k < n - 1 && (phase_out !== cur || ctl_wr !== 1'b0 || irq_req !== 1'b0))
        quiet = 1'b0;
    end
    check(quiet, {tag_len, " phase held without writes"}, 32'(quiet), 32'd1);
    check(phase_out === nx, {tag_len, " phase after run"}, 32'(phase_out), 32'(nx));
    check(ctl_wr === exp_wr, {tag_word, " write strobe"}, 32'(ctl_wr), 32'(exp_wr));
    check(ctl_word === exp_word, {tag_word, " command word"}, 32'(ctl_word), 32'(exp_word));
  endtask

  task automatic run_field(input logic init, input logic [15:0] border,
                           input logic [15:0] len, input logic [15:0] mask,
                           input bit change_len, input logic [15:0] sync_cmd,
                           input logic [15:0] fld_cmd);
    logic p = exp_odd;
    init_done = init; cfg_border = border; cfg_pic_len = len;
    cfg_wake_mask = mask; cfg_sync_cmd = sync_cmd; cfg_field_cmd = fld_cmd;
    // R3 sync length depends on parity, R5 released-sync word
    step(17 + int'(p), 3'd0, 3'd1, 1'b1, 16'h0003, "R3", "R5");
    step(2, 3'd1, 3'd2, 1'b1, sync_cmd, "R3", "R6");
    exp_pend = exp_pend | mask;
    if (p) exp_frame = exp_frame + 1;
    check(irq_req === 1'b1, "R10 irq at top border", 32'(irq_req), 32'd1);
    check(wake_pending === exp_pend, "R10 pending bits", 32'(wake_pending), 32'(exp_pend));
    check(border_out === (init ? border : 16'h8822), "R9 border load",
          32'(border_out), 32'(init ? border : 16'h8822));
    check(frame_count === exp_frame, "R11 frame count", frame_count, exp_frame);
    // R2 lead-in entry writes nothing
    step(13, 3'd2, 3'd3, 1'b0, sync_cmd, "R3", "R6");
    if (change_len) cfg_pic_len = 16'd40; // R8 late change must be ignored
    step(1, 3'd3, 3'd4, 1'b1, fld_cmd, "R3", "R6");
    step(int'(len >> 1) - 1, 3'd4, 3'd5, 1'b1, sync_cmd,
         change_len ? "R8" : "R7", "R6");
    step(12, 3'd5, 3'd0, 1'b1, {4'd0, ~p, 11'h023}, "R3", "R5");
    check(field_odd === ~p, "R4 parity flip", 32'(field_odd), 32'(~p));
    exp_odd = ~p;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    exp_odd = 1'b0; exp_pend = '0; exp_frame = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(phase_out === 3'd0 && field_odd === 1'b0, "R1 phase/parity",
          {field_odd, phase_out}, 32'd0);
    check(ctl_word === 16'h0023 && ctl_wr === 1'b0 && irq_req === 1'b0,
          "R1 command outputs", {ctl_wr, irq_req, ctl_word}, 32'h0023);
    check(wake_pending === 0 && border_out === 0 && frame_count === 0,
          "R1 registers", {wake_pending, border_out}, 32'd0);

    for (int i = 0; i < 5; i++) begin
      logic [48:0] v = VEC[i];
      run_field(v[48], v[47:32], v[31:16], v[15:0], 1'b0,
                16'h4C00 | 16'(i), 16'h6E00 | 16'(i));
    end

    // R1 reset in the middle of a field
    repeat (5) do_tick();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(phase_out === 3'd0 && field_odd === 1'b0, "R1 mid-run reset phase",
          {field_odd, phase_out}, 32'd0);
    check(wake_pending === 0 && frame_count === 0 && ctl_word === 16'h0023,
          "R1 mid-run reset registers", {wake_pending, ctl_word}, 32'h0023);
    exp_odd = 1'b0; exp_pend = '0; exp_frame = '0;

    // R8 picture length changed during lead-in, then a normal odd field
    run_field(1'b1, 16'hABCD, 16'd8, 16'h0200, 1'b1, 16'h4C10, 16'h6E10);
    run_field(1'b0, 16'h0000, 16'd12, 16'h0004, 1'b0, 16'h4C11, 16'h6E11);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule